// File: doc/BRIEF.md
# Constant Off-Time Bridge Chopper

This block switches the four gates of one H-bridge that drives a motor winding. While the bridge is energized, it turns on the diagonal pair that matches the requested polarity. A current-limit trip then starts a one-shot off interval. The comparator that produces the trip sits outside this block and reaches it already synchronized. During the off interval the winding current recirculates along a path set by the decay select. All timing is counted in system clock cycles.

The recirculation path depends on the decay select. In slow decay, only the low-side switch opens and the winding freewheels through the two upper switches. In fast decay, every conducting switch opens. After one dead time, fast decay closes only the low-side switch that lies beside the conducting diode. The high side is never used to rectify, so the current cannot reverse once it reaches zero. Every switch waits at least one dead time after its complementary switch in the same leg opens before it closes. A polarity change passes through an all-off interval of one dead time.

The off-interval length comes from a port. It is sampled when a trip is accepted. The dead time is a parameter. Trips are only acted on while the bridge is in forward drive.

Top module: `chop_bridge_ctl`

## Requirements
- R1: During reset and in any cycle where `en_i` was low at the previous clock edge, all four gate outputs are 0.
- R2: When `en_i` rises, the gates stay all-off for DEAD_CYC cycles. The bridge then drives its diagonal. Gate vector {a_hi,a_lo,b_hi,b_lo} is 4'b1001 when `dir_i`=1 and 4'b0110 when `dir_i`=0.
- R3: A change of `dir_i` in forward drive produces DEAD_CYC all-off cycles and then the new diagonal. A change made during an off interval takes effect after that interval ends, again through DEAD_CYC all-off cycles.
- R4: A trip sampled in forward drive leaves forward drive in the next cycle. Forward drive returns after exactly `off_len_i` + DEAD_CYC cycles.
- R5: Fast decay (`slow_i`=0) runs three phases. First, DEAD_CYC cycles all-off. Second, `off_len_i` − DEAD_CYC cycles with only the source leg's low side on: 4'b0100 for dir 1, 4'b0001 for dir 0. Third, DEAD_CYC cycles all-off.
- R6: Slow decay (`slow_i`=1) runs three phases. First, DEAD_CYC cycles with only the source leg's high side on: 4'b1000 for dir 1, 4'b0010 for dir 0. Second, `off_len_i` − DEAD_CYC cycles with both high sides on (4'b1010). Third, DEAD_CYC cycles with the source high side alone.
- R7: A trip that arrives during an off interval, its dead times, or the all-off arming interval has no effect on the gate sequence.
- R8: The decay select is captured when a trip is accepted. Changing `slow_i` during the off interval does not alter that interval.
- R9: A leg never has its high and low side on together. No switch turns on fewer than DEAD_CYC cycles after its complementary switch in the same leg was last on.
- R10: `off_len_i` is sampled when a trip is accepted. Changing it during the off interval does not alter that interval. Values must exceed DEAD_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Energize the winding |
| dir_i | input | 1 | Polarity: 1 drives leg A high / leg B low |
| slow_i | input | 1 | Decay select: 1 slow, 0 fast |
| trip_i | input | 1 | Synchronized current-limit trip |
| off_len_i | input | OFF_W | Off interval in cycles (from trip to end of the recirculation hold) |
| gate_a_hi_o | output | 1 | Leg A high-side gate |
| gate_a_lo_o | output | 1 | Leg A low-side gate |
| gate_b_hi_o | output | 1 | Leg B high-side gate |
| gate_b_lo_o | output | 1 | Leg B low-side gate |

## Verification
The bench builds the block with DEAD_CYC=3 and OFF_W=8 in place of the defaults (200 and 12). With these values, each off interval finishes in a dozen or so cycles, so every gate run can be timed to the exact cycle. The off interval is driven at 10 and also at 5. At 5 the hold phase shrinks to two cycles, which tests the subtraction of the dead time from the programmed length. The short dead time also lets the trip, direction and decay-select inputs be changed inside each individual phase.

// File: rtl/chop_pkg.sv
// Shared definitions for the bridge chopper.
// Assumes: gate vectors are ordered {a_hi, a_lo, b_hi, b_lo}.
package chop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,     // bridge not energized, all gates off
        ST_ARM,      // all-off dead time before a diagonal turns on
        ST_DRIVE,    // forward diagonal on, trips accepted
        ST_OFF_DT,   // first dead time of the off interval
        ST_OFF_HOLD, // recirculation hold of the off interval
        ST_REC_DT    // dead time before forward drive resumes
    } chop_state_t;

    localparam int GATE_A_HI = 3;
    localparam int GATE_A_LO = 2;
    localparam int GATE_B_HI = 1;
    localparam int GATE_B_LO = 0;

endpackage

// File: rtl/chop_timer.sv
// Down-counter shared by all timed phases of the chopper.
// Assumes: a load of N-1 on entry to a phase makes that phase last N cycles;
// done is high in the last cycle of the phase.
module chop_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/chop_seq.sv
// Phase sequencer: arming, forward drive, the three-part off interval.
// Assumes: trip_i is already synchronized; off_len_i > DEAD_CYC when a trip lands.
// Captures polarity on arming, and decay mode plus hold length on a trip.
module chop_seq
    import chop_pkg::*;
#(
    parameter int DEAD_CYC = 200,
    parameter int OFF_W    = 12,
    parameter int CNT_W    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             dir_i,
    input  logic             slow_i,
    input  logic             trip_i,
    input  logic [OFF_W-1:0] off_len_i,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output chop_state_t      state_o,
    output logic             dir_o,
    output logic             slow_o
);

    localparam logic [CNT_W-1:0] DEAD_V  = CNT_W'(DEAD_CYC);
    localparam logic [CNT_W-1:0] DEAD_M1 = CNT_W'(DEAD_CYC - 1);

    chop_state_t      state_q, state_d;
    logic             dir_q, dir_d;
    logic             slow_q, slow_d;
    logic [CNT_W-1:0] hold_q, hold_d;
    logic [CNT_W-1:0] off_ext;
    logic [CNT_W-1:0] hold_len_m1;

    // Hold phase length minus one, from the off length less one dead time.
    always_comb begin
        off_ext     = CNT_W'(off_len_i);
        hold_len_m1 = (off_ext > DEAD_V) ? (off_ext - DEAD_V - CNT_W'(1)) : '0;
    end

    // Next phase, captured values and timer load for the current phase.
    always_comb begin
        state_d  = state_q;
        dir_d    = dir_q;
        slow_d   = slow_q;
        hold_d   = hold_q;
        tmr_load = 1'b0;
        tmr_val  = DEAD_M1;
        if (!en_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d  = ST_ARM;
                    dir_d    = dir_i;
                    tmr_load = 1'b1;
                end
                ST_ARM: begin
                    if (dir_i != dir_q) begin
                        dir_d    = dir_i;
                        tmr_load = 1'b1;
                    end else if (tmr_done) begin
                        state_d = ST_DRIVE;
                    end
                end
                ST_DRIVE: begin
                    if (dir_i != dir_q) begin
                        state_d  = ST_ARM;
                        dir_d    = dir_i;
                        tmr_load = 1'b1;
                    end else if (trip_i) begin
                        state_d  = ST_OFF_DT;
                        slow_d   = slow_i;
                        hold_d   = hold_len_m1;
                        tmr_load = 1'b1;
                    end
                end
                ST_OFF_DT: begin
                    if (tmr_done) begin
                        state_d  = ST_OFF_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = hold_q;
                    end
                end
                ST_OFF_HOLD: begin
                    if (tmr_done) begin
                        state_d  = ST_REC_DT;
                        tmr_load = 1'b1;
                    end
                end
                ST_REC_DT: begin
                    if (tmr_done) begin
                        if (dir_i != dir_q) begin
                            state_d  = ST_ARM;
                            dir_d    = dir_i;
                            tmr_load = 1'b1;
                        end else begin
                            state_d = ST_DRIVE;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Phase and captured-value registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b1;
            slow_q  <= 1'b1;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            dir_q   <= dir_d;
            slow_q  <= slow_d;
            hold_q  <= hold_d;
        end
    end

    assign state_o = state_q;
    assign dir_o   = dir_q;
    assign slow_o  = slow_q;

endmodule

// File: rtl/chop_gate_map.sv
// Maps phase, captured polarity and decay mode onto the four gates.
// Assumes: inputs are registers, so the gates change only after a clock edge.
// The source leg is A when dir is 1 and B when dir is 0.
module chop_gate_map
    import chop_pkg::*;
(
    input  chop_state_t state_i,
    input  logic        dir_i,
    input  logic        slow_i,
    output logic [3:0]  gates_o
);

    logic src_hi, src_lo, snk_hi, snk_lo;

    // Role-based switch decode: source leg and sink leg.
    always_comb begin
        src_hi = 1'b0;
        src_lo = 1'b0;
        snk_hi = 1'b0;
        snk_lo = 1'b0;
        unique case (state_i)
            ST_DRIVE: begin
                src_hi = 1'b1;
                snk_lo = 1'b1;
            end
            ST_OFF_DT, ST_REC_DT: src_hi = slow_i;
            ST_OFF_HOLD: begin
                src_hi = slow_i;
                snk_hi = slow_i;
                src_lo = !slow_i;
            end
            default: ;
        endcase
    end

    logic [1:0] leg_hi, leg_lo;

    genvar leg;
    generate
        for (leg = 0; leg < 2; leg++) begin : g_leg
            localparam bit IS_A = (leg == 0);
            // Leg is the source when its side matches the polarity.
            assign leg_hi[leg] = ((IS_A == dir_i) ? src_hi : snk_hi);
            assign leg_lo[leg] = ((IS_A == dir_i) ? src_lo : snk_lo);
        end
    endgenerate

    assign gates_o[GATE_A_HI] = leg_hi[0];
    assign gates_o[GATE_A_LO] = leg_lo[0];
    assign gates_o[GATE_B_HI] = leg_hi[1];
    assign gates_o[GATE_B_LO] = leg_lo[1];

endmodule

// File: rtl/chop_bridge_ctl.sv
// Constant off-time chopper for one H-bridge with slow/fast decay.
// Assumes: synchronous active-low reset, trip already synchronized,
// DEAD_CYC >= 1 and off_len_i > DEAD_CYC whenever a trip is accepted.
module chop_bridge_ctl
    import chop_pkg::*;
#(
    parameter int DEAD_CYC = 200,
    parameter int OFF_W    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             dir_i,
    input  logic             slow_i,
    input  logic             trip_i,
    input  logic [OFF_W-1:0] off_len_i,
    output logic             gate_a_hi_o,
    output logic             gate_a_lo_o,
    output logic             gate_b_hi_o,
    output logic             gate_b_lo_o
);

    localparam int DEAD_W = $clog2(DEAD_CYC + 1);
    localparam int CNT_W  = (OFF_W > DEAD_W) ? OFF_W : DEAD_W;

    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    chop_state_t      state;
    logic             cap_dir, cap_slow;
    logic [3:0]       gates;

    chop_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    chop_seq #(.DEAD_CYC(DEAD_CYC), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .dir_i     (dir_i),
        .slow_i    (slow_i),
        .trip_i    (trip_i),
        .off_len_i (off_len_i),
        .tmr_done  (tmr_done),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .state_o   (state),
        .dir_o     (cap_dir),
        .slow_o    (cap_slow)
    );

    chop_gate_map u_map (
        .state_i (state),
        .dir_i   (cap_dir),
        .slow_i  (cap_slow),
        .gates_o (gates)
    );

    assign gate_a_hi_o = gates[GATE_A_HI];
    assign gate_a_lo_o = gates[GATE_A_LO];
    assign gate_b_hi_o = gates[GATE_B_HI];
    assign gate_b_lo_o = gates[GATE_B_LO];

endmodule

// File: rtl/chop_bridge_ctl_chk.sv
// Port-level properties of the bridge chopper, bound onto every instance.
// Assumes: the same DEAD_CYC as the checked instance.
module chop_bridge_ctl_chk #(
    parameter int DEAD_CYC = 200
) (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic dir_i,
    input logic trip_i,
    input logic gate_a_hi_o,
    input logic gate_a_lo_o,
    input logic gate_b_hi_o,
    input logic gate_b_lo_o
);

    localparam int GW = $clog2(DEAD_CYC + 1) + 1;

    logic [3:0] g;
    logic [3:0] fwd;
    assign g   = {gate_a_hi_o, gate_a_lo_o, gate_b_hi_o, gate_b_lo_o};
    assign fwd = dir_i ? 4'b1001 : 4'b0110;

    // R9: no leg conducts through both of its switches.
    assert_no_shoot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_a_hi_o && gate_a_lo_o) && !(gate_b_hi_o && gate_b_lo_o));

    // R1: a low energize input clears every gate on the next cycle.
    assert_off_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (g == 4'b0000));

    // R7: forward drive holds while energized, polarity steady and no trip.
    assert_drive_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !trip_i && g == fwd) |=> (g == $past(g)));

    // R4: a trip seen in forward drive ends forward drive at once.
    assert_trip_leaves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && trip_i && g == fwd) |=> (g != $past(g)));

    genvar k;
    generate
        for (k = 0; k < 4; k++) begin : g_sw
            logic [GW-1:0] gap_q;
            // Cycles since the complementary switch of this leg was last on.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    gap_q <= GW'(DEAD_CYC);
                else if (g[k ^ 1])
                    gap_q <= '0;
                else if (gap_q < GW'(DEAD_CYC))
                    gap_q <= gap_q + GW'(1);
            end
            // R9: a switch closes only after a full dead time.
            assert_dead_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(g[k]) |-> (gap_q >= GW'(DEAD_CYC)));
        end
    endgenerate

endmodule

bind chop_bridge_ctl chop_bridge_ctl_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .dir_i       (dir_i),
    .trip_i      (trip_i),
    .gate_a_hi_o (gate_a_hi_o),
    .gate_a_lo_o (gate_a_lo_o),
    .gate_b_hi_o (gate_b_hi_o),
    .gate_b_lo_o (gate_b_lo_o)
);

// File: tb/chop_bridge_ctl_tb.sv
// Scoreboard bench: the driver queues expected gate runs, the monitor
// measures each run of a constant gate vector and compares it.
module chop_bridge_ctl_tb;

    localparam int DEAD = 3;
    localparam int OW   = 8;

    typedef struct {
        logic [3:0] v;
        int         len;   // 0: length not checked
        string      req;
    } seg_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0, dir = 1'b1, slow = 1'b1, trip = 1'b0;
    logic [OW-1:0] off_len = OW'(10);
    logic          a_hi, a_lo, b_hi, b_lo;
    logic [3:0]    g;

    int   checks = 0;
    int   errors = 0;
    seg_t exp_q[$];
    logic [3:0] cur = 4'b0000;
    int   run = 0;
    bit   mon_on = 0;

    always #2.5 clk = ~clk;

    chop_bridge_ctl #(.DEAD_CYC(DEAD), .OFF_W(OW)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .dir_i(dir), .slow_i(slow),
        .trip_i(trip), .off_len_i(off_len),
        .gate_a_hi_o(a_hi), .gate_a_lo_o(a_lo),
        .gate_b_hi_o(b_hi), .gate_b_lo_o(b_lo)
    );

    assign g = {a_hi, a_lo, b_hi, b_lo};

    task automatic push(input logic [3:0] v, input int len, input string req);
        seg_t s;
        s.v = v; s.len = len; s.req = req;
        exp_q.push_back(s);
    endtask

    task automatic check_now(input logic [3:0] e, input string req);
        checks++;
        if (g !== e) begin
            errors++;
            $display("FAIL %s gates actual=%b expected=%b", req, g, e);
        end
    endtask

    task automatic fire_trip();
        @(negedge clk); trip = 1'b1;
        @(negedge clk); trip = 1'b0;
    endtask

    // Monitor: close a run when the gate vector changes and score it.
    always @(negedge clk) begin
        if (mon_on) begin
            if (g === cur) begin
                run++;
            end else begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R4 unexpected run actual=%b/%0d expected=none", cur, run);
                end else begin
                    seg_t e;
                    e = exp_q.pop_front();
                    if (e.v !== cur || (e.len != 0 && e.len != run)) begin
                        errors++;
                        $display("FAIL %s run actual=%b/%0d expected=%b/%0d",
                                 e.req, cur, run, e.v, e.len);
                    end
                end
                cur = g;
                run = 1;
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset value, then arming run merges with it.
        push(4'b0000, 0, "R1");
        push(4'b1001, 0, "R2");
        repeat (3) @(negedge clk);
        check_now(4'b0000, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_now(4'b0000, "R1");
        mon_on = 1;

        // R2: energize, DEAD all-off cycles, then diagonal 1001.
        en = 1'b1;
        for (int i = 0; i < DEAD; i++) begin
            @(negedge clk);
            check_now(4'b0000, "R2");
        end
        @(negedge clk);
        check_now(4'b1001, "R2");
        repeat (8) @(negedge clk);

        // R6 and R4: slow decay, dir 1, off length 10.
        push(4'b1000, DEAD, "R6");
        push(4'b1010, 7, "R6");
        push(4'b1000, DEAD, "R4");
        push(4'b1001, 0, "R4");
        fire_trip();
        repeat (20) @(negedge clk);

        // R5 and R7: fast decay with trips injected inside each phase.
        slow = 1'b0;
        push(4'b0000, DEAD, "R5");
        push(4'b0100, 7, "R5");
        push(4'b0000, DEAD, "R7");
        push(4'b1001, 0, "R7");
        fire_trip();
        trip = 1'b1; @(negedge clk); trip = 1'b0;
        repeat (3) @(negedge clk);
        trip = 1'b1; @(negedge clk); trip = 1'b0;
        repeat (3) @(negedge clk);
        trip = 1'b1; @(negedge clk); trip = 1'b0;
        repeat (20) @(negedge clk);

        // R8: decay select changed mid-interval keeps slow phases.
        slow = 1'b1;
        push(4'b1000, DEAD, "R8");
        push(4'b1010, 7, "R8");
        push(4'b1000, DEAD, "R8");
        push(4'b1001, 0, "R8");
        fire_trip();
        repeat (4) @(negedge clk);
        slow = 1'b0;
        repeat (20) @(negedge clk);

        // R3: polarity change in drive, with a trip during arming (R7).
        push(4'b0000, DEAD, "R3");
        push(4'b0110, 0, "R3");
        dir = 1'b0;
        @(negedge clk); trip = 1'b1;
        @(negedge clk); trip = 1'b0;
        repeat (10) @(negedge clk);

        // R6: slow decay, dir 0.
        slow = 1'b1;
        push(4'b0010, DEAD, "R6");
        push(4'b1010, 7, "R6");
        push(4'b0010, DEAD, "R6");
        push(4'b0110, 0, "R6");
        fire_trip();
        repeat (20) @(negedge clk);

        // R10 and R5: fast decay dir 0, off length 5, changed mid-interval.
        slow = 1'b0;
        off_len = OW'(5);
        push(4'b0000, DEAD, "R5");
        push(4'b0001, 2, "R10");
        push(4'b0000, DEAD, "R10");
        push(4'b0110, 0, "R10");
        fire_trip();
        off_len = OW'(20);
        repeat (20) @(negedge clk);

        // R3: polarity change requested during the off interval.
        off_len = OW'(10);
        slow = 1'b1;
        push(4'b0010, DEAD, "R6");
        push(4'b1010, 7, "R6");
        push(4'b0010, DEAD, "R3");
        push(4'b0000, DEAD, "R3");
        push(4'b1001, 0, "R3");
        fire_trip();
        repeat (5) @(negedge clk);
        dir = 1'b1;
        repeat (20) @(negedge clk);

        // R1: de-energize from forward drive.
        push(4'b0000, 0, "R1");
        en = 1'b0;
        @(negedge clk);
        check_now(4'b0000, "R1");
        repeat (5) @(negedge clk);

        // Only the open final run may remain.
        checks++;
        if (exp_q.size() != 1 || exp_q[0].v !== cur) begin
            errors++;
            $display("FAIL R1 final actual=%b/%0d left expected=0000/1 left",
                     cur, exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule